// File: doc/BRIEF.md
# Round-Robin Interleaved Processing Element

This block lets a slow combinational function keep up with a fast clock. The function is instantiated `NWAY` times. A free-running modulo-`NWAY` pointer steers each clock's input sample into one copy's operand register, so every copy keeps a stable operand for `NWAY` clocks while its logic settles. On the clock when a copy's operand is about to be replaced, its settled result is captured into the output register. One result can leave per clock even though each copy needs `NWAY` periods.

The replicated function is a multiply-add: the result is the input times `MUL_K` plus `ADD_K`, kept to `OUT_W` bits. A valid bit travels with each operand, so gaps in the input stream show up as gaps in the output stream. Latency is a fixed `NWAY` clocks, and results leave in arrival order.

Top module: `rr_interleaver`

## Requirements
- R1: While `rst` is high at a rising edge, the next output state is `out_valid` = 0 and `out_data` = 0.
- R2: `out_valid` is high in the cycle that follows the `NWAY`-th rising edge after an edge that sampled `in_valid` high. It is low in every other cycle.
- R3: Each valid result equals (`in_data` * `MUL_K` + `ADD_K`) modulo 2^`OUT_W` for the sample accepted `NWAY` clocks earlier. Each copy's operand stays unchanged until the pointer returns to that copy.
- R4: An unbroken run of input samples, one per clock, produces an unbroken run of results, one per clock, with no bubble.
- R5: Results leave in the order the samples arrived, including when the input has irregular gaps. The steering pointer advances by one each clock and wraps from `NWAY`-1 to 0.
- R6: `out_data` holds its last value in every cycle where `out_valid` is low. `in_data` presented with `in_valid` low never reaches the output.
- R7: A reset in the middle of a stream discards every sample accepted before it. The first sample accepted after reset appears exactly `NWAY` clocks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | IN_W | Input sample |
| out_valid | output | 1 | Result present this cycle (registered) |
| out_data | output | OUT_W | Result (registered) |

## Verification
Two actions share a clock edge when the pointer comes back to a copy. The output register takes that copy's finished result, and the same copy's operand register loads the next sample. A continuous back-to-back stream forces this on every edge. The bench checks that each result still matches the older sample and never the one being loaded. A reset asserted while samples are in flight is the second collision. The bench checks that no stale result leaks out afterwards and that the first new sample arrives on time.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // Width of a pointer that counts 0 .. n-1 (never below one bit).
  function automatic int ilv_ptr_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ilv_steer.sv
module ilv_steer #(
  parameter int NWAY = 4,
  localparam int PW = ilv_pkg::ilv_ptr_w(NWAY)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PW-1:0]   ptr,
  output logic [NWAY-1:0] load_sel
);
  localparam logic [PW-1:0] LAST = PW'(NWAY - 1);

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (ptr == LAST) ptr <= '0;
    else ptr <= ptr + PW'(1);
  end

  for (genvar k = 0; k < NWAY; k++) begin : g_dec
    assign load_sel[k] = (ptr == PW'(k));
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (ptr != LAST) |=> (ptr == $past(ptr) + PW'(1))); // R5
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ptr == LAST) |=> (ptr == '0)); // R5
  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (rst)
    $onehot(load_sel)); // R4
endmodule

// File: rtl/ilv_muladd.sv
module ilv_muladd #(
  parameter int          IN_W  = 16,
  parameter int          OUT_W = 32,
  parameter int unsigned MUL_K = 40503,
  parameter int unsigned ADD_K = 12345
) (
  input  logic [IN_W-1:0]  opnd,
  output logic [OUT_W-1:0] res
);
  // Slow path: allowed NWAY clock periods to settle.
  always_comb res = OUT_W'(OUT_W'(opnd) * OUT_W'(MUL_K)) + OUT_W'(ADD_K);
endmodule

// File: rtl/ilv_lane.sv
module ilv_lane #(
  parameter int          IN_W  = 16,
  parameter int          OUT_W = 32,
  parameter int unsigned MUL_K = 40503,
  parameter int unsigned ADD_K = 12345
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             lane_valid,
  output logic [OUT_W-1:0] lane_res
);
  logic [IN_W-1:0] opnd;

  // Valid bit is rewritten on every turn of this lane.
  always_ff @(posedge clk) begin
    if (rst) lane_valid <= 1'b0;
    else if (load) lane_valid <= in_valid;
  end

  // Operand register: no reset, loads only on a valid sample for this lane.
  always_ff @(posedge clk) begin
    if (load && in_valid) opnd <= in_data;
  end

  ilv_muladd #(.IN_W(IN_W), .OUT_W(OUT_W), .MUL_K(MUL_K), .ADD_K(ADD_K)) u_elem (
    .opnd (opnd),
    .res  (lane_res)
  );

  AST_OPND_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(opnd)); // R3
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(lane_valid)); // R3
endmodule

// File: rtl/rr_interleaver.sv
module rr_interleaver #(
  parameter int          NWAY  = 4,
  parameter int          IN_W  = 16,
  parameter int          OUT_W = 32,
  parameter int unsigned MUL_K = 40503,
  parameter int unsigned ADD_K = 12345
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  localparam int PW = ilv_pkg::ilv_ptr_w(NWAY);

  logic [PW-1:0]    ptr;
  logic [NWAY-1:0]  load_sel;
  logic [NWAY-1:0]  lane_vld;
  logic [OUT_W-1:0] lane_res [NWAY];

  ilv_steer #(.NWAY(NWAY)) u_steer (
    .clk      (clk),
    .rst      (rst),
    .ptr      (ptr),
    .load_sel (load_sel)
  );

  for (genvar k = 0; k < NWAY; k++) begin : g_lane
    ilv_lane #(.IN_W(IN_W), .OUT_W(OUT_W), .MUL_K(MUL_K), .ADD_K(ADD_K)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .load       (load_sel[k]),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .lane_valid (lane_vld[k]),
      .lane_res   (lane_res[k])
    );
  end

  // The lane being reloaded this edge is the one loaded NWAY edges ago:
  // capture its settled result before the new operand replaces it.
  logic             due_vld;
  logic [OUT_W-1:0] due_res;
  always_comb begin
    due_vld = lane_vld[ptr];
    due_res = lane_res[ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= due_vld;
      if (due_vld) out_data <= due_res;
    end
  end

  // Shadow delay line of accepted valids, used only by the latency check.
  logic [NWAY-1:0] vshadow;
  always_ff @(posedge clk) begin
    if (rst) vshadow <= '0;
    else begin
      vshadow[0] <= in_valid;
      for (int i = 1; i < NWAY; i++) vshadow[i] <= vshadow[i-1];
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    vshadow[NWAY-1] |=> out_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !vshadow[NWAY-1] |=> !out_valid); // R2
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_data == '0)); // R1
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data)); // R6
endmodule

// File: tb/rr_interleaver_tb.sv
module rr_interleaver_tb;
  localparam int          N     = 4;
  localparam int          DW    = 16;
  localparam int          OW    = 32;
  localparam int unsigned MULK  = 40503;
  localparam int unsigned ADDK  = 12345;
  localparam int          DEPTH = 1024;
  localparam int          NVEC  = 24;

  // {valid, data}
  localparam logic [DW:0] VEC [NVEC] = '{
    {1'b1, 16'h0000}, {1'b1, 16'hFFFF}, {1'b1, 16'h0001}, {1'b0, 16'hDEAD},
    {1'b1, 16'h8000}, {1'b1, 16'h1234}, {1'b0, 16'hBEEF}, {1'b0, 16'h0F0F},
    {1'b1, 16'h7FFF}, {1'b1, 16'hA5A5}, {1'b1, 16'h5A5A}, {1'b1, 16'h00FF},
    {1'b1, 16'hFF00}, {1'b0, 16'h1111}, {1'b1, 16'h0002}, {1'b0, 16'h2222},
    {1'b1, 16'hC0DE}, {1'b1, 16'h4321}, {1'b0, 16'h3333}, {1'b0, 16'h4444},
    {1'b0, 16'h5555}, {1'b1, 16'h9999}, {1'b1, 16'hFFFE}, {1'b1, 16'h0100}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [OW-1:0] out_data;

  int            cyc = 0;
  int            errors = 0;
  int            checks = 0;
  bit            exp_v [DEPTH];
  logic [OW-1:0] exp_d [DEPTH];
  logic [OW-1:0] last_d = '0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rr_interleaver #(.NWAY(N), .IN_W(DW), .OUT_W(OW), .MUL_K(MULK), .ADD_K(ADDK)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  function automatic logic [OW-1:0] ref_fn(input logic [DW-1:0] x);
    logic [OW-1:0] p;
    p = OW'(x) * OW'(MULK);
    return p + OW'(ADDK);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [OW-1:0] act,
                     input logic [OW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: cycle %0d actual=%h expected=%h", req, cyc, act, expv);
    end
  endtask

  // Check this cycle's outputs, then present the next input.
  task automatic step(input bit v, input logic [DW-1:0] d, input string req);
    @(negedge clk);
    chk(out_valid == exp_v[cyc], req, OW'(out_valid), OW'(exp_v[cyc]));
    if (exp_v[cyc]) begin
      chk(out_data == exp_d[cyc], req, out_data, exp_d[cyc]);
      last_d = exp_d[cyc];
    end else begin
      chk(out_data == last_d, "R6", out_data, last_d);
    end
    in_valid = v;
    in_data  = d;
    if (v && cyc + 1 + N < DEPTH) begin
      exp_v[cyc + 1 + N] = 1'b1;
      exp_d[cyc + 1 + N] = ref_fn(d);
    end
  endtask

  task automatic do_reset(input int edges);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    for (int i = cyc + 1; i < DEPTH; i++) exp_v[i] = 1'b0;
    repeat (edges) @(negedge clk);
    chk(out_valid == 1'b0, "R1", OW'(out_valid), '0);
    chk(out_data == '0, "R1", out_data, '0);
    last_d = '0;
    rst = 1'b0;
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b0, DW'($urandom), req);
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      exp_v[i] = 1'b0;
      exp_d[i] = '0;
    end
    // R1: power-up reset
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", OW'(out_valid), '0);
    chk(out_data == '0, "R1", out_data, '0);
    rst = 1'b0;

    // R3 / R5: vector table with gaps
    for (int i = 0; i < NVEC; i++) step(VEC[i][DW], VEC[i][DW-1:0], "R3");
    idle(N + 2, "R2");

    // R4: back-to-back stream, every edge collides capture with reload
    for (int i = 0; i < 40; i++) step(1'b1, DW'($urandom), "R4");
    idle(N + 2, "R4");

    // R5: irregular gaps, order preserved
    for (int i = 0; i < 30; i++) step((i % 3) != 1 && (i % 7) != 5, DW'($urandom), "R5");
    idle(N + 2, "R5");

    // R6: data without valid never appears, output data holds
    idle(12, "R6");

    // R7: reset with samples in flight
    for (int i = 0; i < N - 1; i++) step(1'b1, DW'($urandom), "R7");
    do_reset(2);
    idle(N + 2, "R7");
    step(1'b1, 16'h2468, "R7");
    idle(N + 3, "R7");
    for (int i = 0; i < 10; i++) step(1'b1, DW'(i * 4099), "R7");
    idle(N + 2, "R7");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule